// File: doc/BRIEF.md
# Carrier-Clocked Serial Byte Link

This block is the device end of a byte-wide synchronous serial link to a host controller. It runs entirely from the carrier clock. It generates the link bit clock and the frame marker on its own, so the host only follows. Each frame moves one 8-bit word in each direction. The outgoing word is shifted out most significant bit first. The incoming word is built from one host bit sampled per bit clock. Firmware writes the outgoing word into a one-entry holding register. The block copies that register into its shifter at the start of every frame.

A small SPI slave, with the host as master, receives 16-bit configuration words. A set-mode command selects one of four operating modes: reader, sniff, simulate and passthrough. The mode sets three things. It sets the bit-clock divide ratio, which is 8 in sniff and 16 otherwise. It sets whether the carrier output runs. It sets whether the serializer is in the data path at all. In passthrough, a raw comparator bit goes straight to the host, and the host's data line drives the modulation control directly. Every accepted mode write restarts the divider and the bit counter, so the first frame in the new mode is whole.

Top module: `carrier_serial_link`

## Requirements
- R1: After reset the mode is reader, `linkFrame` is 1, `linkClk` is 0, `linkDout` is 0, and `rxValid` and `modOut` are 0.
- R2: `linkClk` has a period of 8 carrier cycles in sniff mode and 16 in reader, simulate and passthrough. Each period is low for its first half and high for its second half.
- R3: `linkFrame` is high for exactly the first bit period of each frame, so it is high once every 8 bit clocks.
- R4: `txLoad` writes `txData` into the holding register. At each frame start the holding register is copied to the shifter. `linkDout` presents that word most significant bit first and changes only on falling edges of `linkClk`.
- R5: `linkDin` is sampled on each rising edge of `linkClk`, most significant bit first. After the eighth bit of a frame, `rxByte` holds the word and `rxValid` pulses high for one cycle.
- R6: `carrierOut` is the inverted carrier clock in reader, simulate and passthrough. It is held at 0 in sniff.
- R7: In passthrough, `linkDout` follows `cmpRaw`, `modOut` follows `linkDin` (1 = modulate, 0 = listen), and `rxValid` never pulses. In every other mode `modOut` is 0.
- R8: A configuration word is 16 bits long. It is sampled on rising SPI clock edges, most significant bit first, and acted on when chip select deasserts. If bits [15:12] are 4'hA, bits [1:0] become the mode: 00 reader, 01 sniff, 10 simulate, 11 passthrough.
- R9: A word whose command field is not 4'hA, or a transfer of any length other than 16 bits, leaves the mode unchanged.
- R10: An accepted write restarts the link. On the third carrier edge after chip select rises, the frame begins at bit 0 with `linkClk` low. The first rising edge of `linkClk` follows one half period (in the new mode) later and carries `linkFrame` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spiSck | input | 1 | Configuration SPI clock from host |
| spiCsN | input | 1 | Configuration SPI chip select, active low |
| spiMosi | input | 1 | Configuration SPI data from host |
| txLoad | input | 1 | Write strobe for the outgoing holding register |
| txData | input | 8 | Word to send to the host |
| cmpRaw | input | 1 | Raw comparator bit for passthrough |
| linkDin | input | 1 | Serial data from host |
| linkClk | output | 1 | Device-generated bit clock |
| linkFrame | output | 1 | Frame marker, high during bit 0 |
| linkDout | output | 1 | Serial data to host |
| modOut | output | 1 | Modulation control |
| carrierOut | output | 1 | Gated inverted carrier |
| rxValid | output | 1 | One-cycle strobe: received word ready |
| rxByte | output | 8 | Last word received from host |

## Verification
The hardest situation to reach from the ports is a mode write whose chip-select release falls in the middle of a frame, at a known phase of the old bit clock. Without that, it cannot be told whether the restart truly cleared both counters. The bench therefore keeps chip select low after the last SPI bit. It waits for a rising bit-clock edge that does not carry the frame marker, and only then releases chip select. It then counts carrier edges to the next rising bit-clock edge and checks that the frame marker is present on it. The scoreboard phases begin only after a frame marker falls. This keeps each holding-register write well away from a frame load.

// File: rtl/csl_pkg.sv
package csl_pkg;

  typedef enum logic [1:0] {
    MODE_READER = 2'b00,
    MODE_SNIFF  = 2'b01,
    MODE_SIM    = 2'b10,
    MODE_PASS   = 2'b11
  } linkMode_e;

  localparam logic [3:0] CMD_SET_MODE = 4'hA;

  // strobes from the timing control to the data path
  typedef struct packed {
    logic restart;     // accepted mode write: start a clean frame
    logic loadStb;     // copy holding register into shifter
    logic shiftStb;    // falling bit-clock edge: advance outgoing bit
    logic sampleStb;   // rising bit-clock edge: take host bit
    logic lastSample;  // sample of the final bit of the frame
  } linkStb_t;

endpackage

// File: rtl/csl_cfg_spi.sv
module csl_cfg_spi
  import csl_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int CMD_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      spiSck,
  input  logic      spiCsN,
  input  logic      spiMosi,
  output linkMode_e modeReg,
  output logic      cfgWrite
);

  localparam int CNT_W = $clog2(CFG_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CFG_W + 1);

  logic [SYNC_STAGES-1:0] sckSync, csSync, mosiSync;
  logic sckPrev, csPrev;
  logic sckQ, csQ, mosiQ;
  logic sckRise, csRise;
  logic [CFG_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCount;
  logic [CMD_W-1:0] cmdField;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], spiSck};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
      sckPrev  <= sckQ;
      csPrev   <= csQ;
    end
  end

  assign sckQ    = sckSync[SYNC_STAGES-1];
  assign csQ     = csSync[SYNC_STAGES-1];
  assign mosiQ   = mosiSync[SYNC_STAGES-1];
  assign sckRise = sckQ & ~sckPrev;
  assign csRise  = csQ & ~csPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      bitCount <= '0;
    end else if (csQ) begin
      bitCount <= '0;
    end else if (sckRise) begin
      shiftReg <= {shiftReg[CFG_W-2:0], mosiQ};
      if (bitCount != CNT_OVER) bitCount <= bitCount + 1'b1;
    end
  end

  assign cmdField = shiftReg[CFG_W-1 -: CMD_W];
  assign cfgWrite = csRise && (bitCount == CNT_FULL) && (cmdField == CMD_SET_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        modeReg <= MODE_READER;
    else if (cfgWrite) modeReg <= linkMode_e'(shiftReg[1:0]);
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWrite |=> $stable(modeReg)); // R9

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrite |=> (modeReg == linkMode_e'($past(shiftReg[1:0])))); // R8

endmodule

// File: rtl/csl_ctrl.sv
module csl_ctrl
  import csl_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DIV_SNIFF = 8,
  parameter int DIV_OTHER = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  linkMode_e mode,
  input  logic      cfgWrite,
  output linkStb_t  stb,
  output logic      linkClk,
  output logic      linkFrame
);

  localparam int DIV_W = $clog2(DIV_OTHER);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [DIV_W-1:0] divCnt, divLimit, divHalf;
  logic [BIT_W-1:0] bitCnt;
  logic wrap;

  always_comb begin
    if (mode == MODE_SNIFF) begin
      divLimit = DIV_W'(DIV_SNIFF - 1);
      divHalf  = DIV_W'(DIV_SNIFF / 2);
    end else begin
      divLimit = DIV_W'(DIV_OTHER - 1);
      divHalf  = DIV_W'(DIV_OTHER / 2);
    end
  end

  assign wrap = !cfgWrite && (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (cfgWrite) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (wrap) begin
      divCnt <= '0;
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    stb.restart    = cfgWrite;
    stb.shiftStb   = wrap;
    stb.loadStb    = cfgWrite || (wrap && (bitCnt == LAST_BIT));
    stb.sampleStb  = !cfgWrite && (divCnt == divHalf - 1'b1);
    stb.lastSample = stb.sampleStb && (bitCnt == LAST_BIT);
  end

  assign linkClk   = (divCnt >= divHalf);
  assign linkFrame = (bitCnt == '0);

  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    stb.restart |=> (divCnt == '0 && bitCnt == '0)); // R10

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.shiftStb, stb.sampleStb})); // R2

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkFrame) |-> ($past(bitCnt) == LAST_BIT || $past(stb.restart))); // R3

endmodule

// File: rtl/csl_datapath.sv
module csl_datapath
  import csl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  linkStb_t          stb,
  input  logic              modeIsPass,
  input  logic              txLoad,
  input  logic [WORD_W-1:0] txData,
  input  logic              linkDin,
  input  logic              cmpRaw,
  output logic              linkDout,
  output logic              modOut,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxByte
);

  logic [WORD_W-1:0] holding, shifter, rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      holding <= '0;
    else if (txLoad) holding <= txData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shifter <= '0;
    else if (stb.loadStb)  shifter <= holding;
    else if (stb.shiftStb) shifter <= {shifter[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.lastSample && !modeIsPass;
      if (stb.sampleStb) rxShift <= {rxShift[WORD_W-2:0], linkDin};
      if (stb.lastSample && !modeIsPass) rxByte <= {rxShift[WORD_W-2:0], linkDin};
    end
  end

  assign linkDout = modeIsPass ? cmpRaw : shifter[WORD_W-1];
  assign modOut   = modeIsPass & linkDin;

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadStb |=> (shifter == $past(holding))); // R4

  AST_RX_NOT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> !$past(modeIsPass)); // R7

endmodule

// File: rtl/carrier_serial_link.sv
module carrier_serial_link
  import csl_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int DIV_SNIFF   = 8,
  parameter int DIV_OTHER   = 16,
  parameter int CFG_W       = 16,
  parameter int CMD_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiMosi,
  input  logic              txLoad,
  input  logic [WORD_W-1:0] txData,
  input  logic              cmpRaw,
  input  logic              linkDin,
  output logic              linkClk,
  output logic              linkFrame,
  output logic              linkDout,
  output logic              modOut,
  output logic              carrierOut,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxByte
);

  linkMode_e modeReg;
  logic      cfgWrite;
  linkStb_t  stb;
  logic      modeIsPass, modeIsSniff;

  csl_cfg_spi #(.CFG_W(CFG_W), .CMD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) cfg_i (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .modeReg(modeReg), .cfgWrite(cfgWrite));

  csl_ctrl #(.WORD_W(WORD_W), .DIV_SNIFF(DIV_SNIFF), .DIV_OTHER(DIV_OTHER)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode(modeReg), .cfgWrite(cfgWrite),
    .stb(stb), .linkClk(linkClk), .linkFrame(linkFrame));

  assign modeIsPass  = (modeReg == MODE_PASS);
  assign modeIsSniff = (modeReg == MODE_SNIFF);

  csl_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .modeIsPass(modeIsPass),
    .txLoad(txLoad), .txData(txData), .linkDin(linkDin), .cmpRaw(cmpRaw),
    .linkDout(linkDout), .modOut(modOut), .rxValid(rxValid), .rxByte(rxByte));

  assign carrierOut = ~clk & ~modeIsSniff;

endmodule

// File: tb/carrier_serial_link_tb_top.sv
module carrier_serial_link_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic txLoad = 1'b0;
  logic [7:0] txData = 8'h00;
  logic cmpRaw = 1'b0, linkDin = 1'b0;
  logic linkClk, linkFrame, linkDout, modOut, carrierOut, rxValid;
  logic [7:0] rxByte;

  always #5 clk = ~clk;

  carrier_serial_link dut_i (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .txLoad(txLoad), .txData(txData), .cmpRaw(cmpRaw), .linkDin(linkDin),
    .linkClk(linkClk), .linkFrame(linkFrame), .linkDout(linkDout), .modOut(modOut),
    .carrierOut(carrierOut), .rxValid(rxValid), .rxByte(rxByte));

  int errors = 0;
  int checks = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit   active = 1'b0;
  int   curPeriod = 16;
  int   framesDone = 0;
  int   rxPops = 0;
  logic [7:0] seed = 8'h5B;

  // monitor state
  logic pClk, pFrame;
  bit   started, seenRise;
  int   cyc, bits;
  logic [7:0] acc, hostByte, expB, drvB;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nextByte();
    seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
    return seed;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor: acts as the host on the link
  initial begin
    forever begin
      @(negedge clk);
      if (!active) begin
        pClk = linkClk; pFrame = linkFrame;
        started = 0; seenRise = 0; cyc = 0; bits = 0;
      end else begin
        cyc++;
        if (linkFrame && !pFrame) begin
          if (started) chk(bits == 8, "R3 bits per frame", bits, 8);
          started = 1; bits = 0; acc = 8'h00;
          hostByte = nextByte();
          rxQ.push_back(hostByte);
          drvB = nextByte();
          txData = drvB; txLoad = 1'b1;
          txQ.push_back(drvB);
        end else if (txLoad) begin
          txLoad = 1'b0;
        end
        if (linkClk && !pClk) begin
          if (seenRise) chk(cyc == curPeriod, "R2 bit-clock period", cyc, curPeriod);
          seenRise = 1; cyc = 0;
          if (started) begin
            chk(linkFrame == (bits == 0), "R3 frame marker", int'(linkFrame), int'(bits == 0));
            acc = {acc[6:0], linkDout};
            bits++;
            if (bits == 8) begin
              expB = txQ.pop_front();
              chk(acc == expB, "R4 word to host", acc, expB);
              framesDone++;
            end
          end
        end
        if (!linkClk && started && bits < 8) linkDin = hostByte[7 - bits];
        if (rxValid && rxQ.size() > 0) begin
          expB = rxQ.pop_front();
          chk(rxByte == expB, "R5 word from host", rxByte, expB);
          rxPops++;
        end
        pClk = linkClk; pFrame = linkFrame;
      end
    end
  end

  task automatic runPhase(input int nFrames, input int period);
    bit seenHigh = 0;
    forever begin
      @(negedge clk);
      if (linkFrame) seenHigh = 1;
      else if (seenHigh) break;
    end
    drvB = nextByte();
    txQ.push_back(drvB);
    txData = drvB; txLoad = 1'b1;
    framesDone = 0; rxPops = 0; curPeriod = period;
    @(negedge clk);
    txLoad = 1'b0;
    active = 1'b1;
    wait (framesDone >= nFrames);
    repeat (3) @(negedge clk);
    active = 1'b0;
    chk(rxPops == framesDone, "R5 one word per frame", rxPops, framesDone);
    txQ.delete(); rxQ.delete();
    txLoad = 1'b0;
  endtask

  task automatic spiBits(input logic [15:0] w, input int nbits);
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = w[15 - i];
      repeat (4) @(negedge clk);
      spiSck = 1'b1;
      repeat (4) @(negedge clk);
      spiSck = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic spiWord(input logic [15:0] w, input int nbits);
    spiBits(w, nbits);
    spiCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // aligned mode write: release chip select at a mid-frame rising bit-clock edge
  task automatic modeChange(input logic [1:0] m, input int half);
    logic pc;
    int k = 0;
    bit seenLow = 0;
    spiBits({4'hA, 10'h000, m}, 16);
    pc = linkClk;
    forever begin
      @(negedge clk);
      if (linkClk && !pc && !linkFrame) break;
      pc = linkClk;
    end
    spiCsN = 1'b1;
    while (k < 60) begin
      @(negedge clk);
      k++;
      if (!linkClk) seenLow = 1;
      else if (seenLow) break;
    end
    chk(k == 3 + half, "R10 first edge after restart", k, 3 + half);
    chk(linkFrame == 1'b1, "R10 first bit is bit 0", int'(linkFrame), 1);
  endtask

  task automatic measurePeriod(output int p);
    logic pc;
    p = 0;
    pc = linkClk;
    forever begin
      @(negedge clk);
      if (linkClk && !pc) break;
      pc = linkClk;
    end
    pc = linkClk;
    forever begin
      @(negedge clk);
      p++;
      if (linkClk && !pc) break;
      pc = linkClk;
    end
  endtask

  task automatic checkCarrier(input logic expLow, input string req);
    @(posedge clk); #1;
    chk(carrierOut == 1'b0, req, int'(carrierOut), 0);
    @(negedge clk); #1;
    chk(carrierOut == expLow, req, int'(carrierOut), int'(expLow));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int p;
    int rxSeen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(linkFrame == 1'b1, "R1 frame", int'(linkFrame), 1);
    chk(linkClk == 1'b0, "R1 clk", int'(linkClk), 0);
    chk(linkDout == 1'b0, "R1 dout", int'(linkDout), 0);
    chk(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
    chk(modOut == 1'b0, "R1 modOut", int'(modOut), 0);
    measurePeriod(p);
    chk(p == 16, "R1 reader after reset", p, 16);

    checkCarrier(1'b1, "R6 reader carrier");
    runPhase(5, 16);

    modeChange(2'b01, 4);            // R8 sniff
    checkCarrier(1'b0, "R6 sniff gated");
    runPhase(5, 8);

    spiWord({4'h5, 12'h000}, 16);    // R9 unknown command
    measurePeriod(p);
    chk(p == 8, "R9 unknown command ignored", p, 8);
    spiWord({4'hA, 12'h000}, 15);    // R9 short transfer
    measurePeriod(p);
    chk(p == 8, "R9 short word ignored", p, 8);
    spiWord({4'hA, 12'h000}, 17);    // R9 long transfer
    measurePeriod(p);
    chk(p == 8, "R9 long word ignored", p, 8);

    modeChange(2'b10, 8);            // simulate
    checkCarrier(1'b1, "R6 simulate carrier");
    runPhase(4, 16);

    spiWord({4'hA, 12'h003}, 16);    // R7 passthrough
    @(negedge clk); cmpRaw = 1'b1; #1;
    chk(linkDout == 1'b1, "R7 comparator to host", int'(linkDout), 1);
    cmpRaw = 1'b0; #1;
    chk(linkDout == 1'b0, "R7 comparator to host", int'(linkDout), 0);
    linkDin = 1'b1; #1;
    chk(modOut == 1'b1, "R7 host modulates", int'(modOut), 1);
    linkDin = 1'b0; #1;
    chk(modOut == 1'b0, "R7 host listens", int'(modOut), 0);
    measurePeriod(p);
    chk(p == 16, "R2 passthrough period", p, 16);
    rxSeen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      linkDin = i[2];
      if (rxValid) rxSeen++;
    end
    chk(rxSeen == 0, "R7 no receive strobe in passthrough", rxSeen, 0);

    modeChange(2'b00, 8);            // back to reader
    @(negedge clk); linkDin = 1'b1; #1;
    chk(modOut == 1'b0, "R7 modOut idle in reader", int'(modOut), 0);
    runPhase(3, 16);

    finishRun();
  end

endmodule